// File: doc/BRIEF.md
# MMIO Address-to-Port Router

This block decides which of eight downstream ports receives a CPU memory-mapped I/O access. Each request address is compared against two kinds of programmable windows. One shared window, the distributed window, is cut into eight equal slices, and each slice belongs to one port in ascending order. Four directed windows each send their whole range to a single port named in a route register. A directed window overrides the distributed window wherever the two overlap.

Software sets up every window through a small register interface. Each window has a base register, a mask register and a route register. A write takes effect on the next clock edge. A read returns the addressed register combinationally.

Requests enter through a valid/ready handshake. The decode result comes out one cycle later through a one-entry output register, also under valid/ready. The result holds still while the consumer holds `rsp_ready` low. A new request is taken only when the output register is empty, or is being drained in that same cycle. So `req_ready` equals `!rsp_valid || rsp_ready`.

Top module: `mmio_port_router`

## Requirements
- R1: Register map (byte offsets on `cfg_addr`):
  - Directed window k (k = 0..3) has its base at 0x300 + 0x18·k, its mask at base offset + 8, and its route at base offset + 0x10.
  - The distributed window has its base at 0x360, mask at 0x368 and route at 0x370.
  - All registers reset to zero and read back the last value written.
  - Any other offset reads as zero, and writes to it change nothing.
- R2: Bit 0 of a base register enables its window. Bit 0 is treated as zero when the window's start address is formed.
- R3: An enabled window covers the addresses from its start to start + ~mask, both ends included.
- R4: The distributed window is split into eight slices of (~mask >> 3) + 1 bytes each. An address at offset `off` from the start goes to the port numbered floor(off / slice), given as a 3-bit binary number on `rsp_port`.
- R5: A directed window routes its whole range to the port given by bits [2:0] of its route register.
- R6: Where an enabled directed window overlaps the distributed window, the directed window wins. The result then carries `rsp_directed` = 1.
- R7: When several enabled directed windows match, the one with the lowest index wins.
- R8: An address that matches no enabled window gives `rsp_hit` = 0, `rsp_directed` = 0 and `rsp_port` = 0. A distributed window with bit 0 clear never matches.
- R9: A request accepted at one clock edge produces `rsp_valid` = 1 after that edge. `rsp_directed` is 1 for a directed match and 0 for a distributed match.
- R10: While `rsp_valid` = 1 and `rsp_ready` = 0, the response fields stay unchanged and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_directed | output | 1 | A directed window matched |
| rsp_port | output | 3 | Selected port |

## Verification
The bench probes both edges of each window and of the distributed slices.

- An off-by-one in the range compare would misroute the last byte of a window, or claim the first byte past it.
- A wrong slice size would push 0xF47FFFFF or 0xF7000000 into the neighbouring port.
- Overlapping directed windows, one inside another and both inside a distributed slice, expose a reversed priority or a lost override as the wrong port number.
- Clearing enable bits exposes a window that still matches while disabled.
- A stalled response with a changed request behind it exposes a register that overwrites or drops the held result.

// File: rtl/mmio_rtr_pkg.sv
package mmio_rtr_pkg;
  localparam int RTR_ADDR_W = 32;
  localparam int RTR_NPORT  = 8;
  localparam int RTR_NDIR   = 4;
  localparam int RTR_CFG_AW = 12;

  // register offsets
  localparam logic [RTR_CFG_AW-1:0] OFS_DIR0   = 12'h300;
  localparam logic [RTR_CFG_AW-1:0] OFS_STRIDE = 12'h018;
  localparam logic [RTR_CFG_AW-1:0] OFS_DIST   = 12'h360;
  localparam logic [RTR_CFG_AW-1:0] OFS_MASK   = 12'h008;
  localparam logic [RTR_CFG_AW-1:0] OFS_ROUTE  = 12'h010;

  localparam int RTR_PORT_W = $clog2(RTR_NPORT);

  typedef struct packed {
    logic                  hit;
    logic                  directed;
    logic [RTR_PORT_W-1:0] port;
  } route_t;
endpackage

// File: rtl/mmio_rtr_regs.sv
module mmio_rtr_regs
  import mmio_rtr_pkg::*;
#(
  parameter int AW     = RTR_ADDR_W,
  parameter int NDIR   = RTR_NDIR,
  parameter int CFG_AW = RTR_CFG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  output logic [AW-1:0]     dir_base  [NDIR],
  output logic [AW-1:0]     dir_mask  [NDIR],
  output logic [AW-1:0]     dir_route [NDIR],
  output logic [AW-1:0]     dist_base,
  output logic [AW-1:0]     dist_mask,
  output logic [AW-1:0]     dist_route
);
  logic [AW-1:0] rd_dir [NDIR];
  logic [NDIR-1:0] sel_dir;

  for (genvar k = 0; k < NDIR; k++) begin : g_dir
    localparam logic [CFG_AW-1:0] A_B = CFG_AW'(OFS_DIR0 + CFG_AW'(k) * OFS_STRIDE);
    localparam logic [CFG_AW-1:0] A_M = CFG_AW'(A_B + OFS_MASK);
    localparam logic [CFG_AW-1:0] A_R = CFG_AW'(A_B + OFS_ROUTE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_base[k]  <= '0;
        dir_mask[k]  <= '0;
        dir_route[k] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == A_B) dir_base[k]  <= cfg_wdata;
        if (cfg_addr == A_M) dir_mask[k]  <= cfg_wdata;
        if (cfg_addr == A_R) dir_route[k] <= cfg_wdata;
      end
    end

    always_comb begin
      sel_dir[k] = 1'b1;
      rd_dir[k]  = '0;
      if (cfg_addr == A_B)      rd_dir[k] = dir_base[k];
      else if (cfg_addr == A_M) rd_dir[k] = dir_mask[k];
      else if (cfg_addr == A_R) rd_dir[k] = dir_route[k];
      else                      sel_dir[k] = 1'b0;
    end
  end

  localparam logic [CFG_AW-1:0] D_B = OFS_DIST;
  localparam logic [CFG_AW-1:0] D_M = CFG_AW'(OFS_DIST + OFS_MASK);
  localparam logic [CFG_AW-1:0] D_R = CFG_AW'(OFS_DIST + OFS_ROUTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_base  <= '0;
      dist_mask  <= '0;
      dist_route <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == D_B) dist_base  <= cfg_wdata;
      if (cfg_addr == D_M) dist_mask  <= cfg_wdata;
      if (cfg_addr == D_R) dist_route <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == D_B)      cfg_rdata = dist_base;
    else if (cfg_addr == D_M) cfg_rdata = dist_mask;
    else if (cfg_addr == D_R) cfg_rdata = dist_route;
    for (int k = 0; k < NDIR; k++) begin
      if (sel_dir[k]) cfg_rdata = rd_dir[k];
    end
  end
endmodule

// File: rtl/mmio_rtr_window.sv
module mmio_rtr_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] off,
  output logic [AW-1:0] span
);
  logic [AW-1:0] start;

  always_comb begin
    start = {base[AW-1:1], 1'b0};
    span  = ~mask;
    off   = addr - start;
    hit   = base[0] && (addr >= start) && (off <= span);
  end
endmodule

// File: rtl/mmio_rtr_slice.sv
module mmio_rtr_slice #(
  parameter int AW    = 32,
  parameter int NPORT = 8
) (
  input  logic [AW-1:0]            off,
  input  logic [AW-1:0]            span,
  output logic [$clog2(NPORT)-1:0] port
);
  localparam int SH = $clog2(NPORT);
  localparam int WW = AW + SH + 1;

  logic [WW-1:0]    step;
  logic [NPORT-1:0] ge;

  assign step  = WW'(span >> SH) + WW'(1);
  assign ge[0] = 1'b0;

  for (genvar n = 1; n < NPORT; n++) begin : g_thr
    assign ge[n] = WW'(off) >= (step * WW'(n));
  end

  always_comb begin
    port = '0;
    for (int n = 1; n < NPORT; n++) begin
      if (ge[n]) port = SH'(n);
    end
  end
endmodule

// File: rtl/mmio_rtr_pick.sv
module mmio_rtr_pick
  import mmio_rtr_pkg::*;
#(
  parameter int NDIR = RTR_NDIR
) (
  input  logic [NDIR-1:0]       dir_hit,
  input  logic [RTR_PORT_W-1:0] dir_port [NDIR],
  input  logic                  dist_hit,
  input  logic [RTR_PORT_W-1:0] dist_port,
  output route_t                sel
);
  always_comb begin
    sel = '0;
    if (dist_hit) begin
      sel.hit  = 1'b1;
      sel.port = dist_port;
    end
    for (int k = NDIR - 1; k >= 0; k--) begin
      if (dir_hit[k]) begin
        sel.hit      = 1'b1;
        sel.directed = 1'b1;
        sel.port     = dir_port[k];
      end
    end
  end
endmodule

// File: rtl/mmio_port_router.sv
module mmio_port_router
  import mmio_rtr_pkg::*;
#(
  parameter int AW     = RTR_ADDR_W,
  parameter int NDIR   = RTR_NDIR,
  parameter int CFG_AW = RTR_CFG_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [AW-1:0]         cfg_wdata,
  output logic [AW-1:0]         cfg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit,
  output logic                  rsp_directed,
  output logic [RTR_PORT_W-1:0] rsp_port
);
  localparam int PORT_W = RTR_PORT_W;

  logic [AW-1:0] dir_base [NDIR];
  logic [AW-1:0] dir_mask [NDIR];
  logic [AW-1:0] dir_route [NDIR];
  logic [AW-1:0] dist_base, dist_mask, dist_route;

  mmio_rtr_regs #(.AW(AW), .NDIR(NDIR), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dir_base(dir_base), .dir_mask(dir_mask), .dir_route(dir_route),
    .dist_base(dist_base), .dist_mask(dist_mask), .dist_route(dist_route)
  );

  logic [NDIR-1:0]   dir_hit;
  logic [PORT_W-1:0] dir_port [NDIR];

  for (genvar k = 0; k < NDIR; k++) begin : g_dwin
    logic [AW-1:0] d_off, d_span;
    mmio_rtr_window #(.AW(AW)) u_win (
      .base(dir_base[k]), .mask(dir_mask[k]), .addr(req_addr),
      .hit(dir_hit[k]), .off(d_off), .span(d_span)
    );
    assign dir_port[k] = dir_route[k][PORT_W-1:0];
  end

  logic              dist_hit;
  logic [AW-1:0]     dist_off, dist_span;
  logic [PORT_W-1:0] dist_port;

  mmio_rtr_window #(.AW(AW)) u_dist (
    .base(dist_base), .mask(dist_mask), .addr(req_addr),
    .hit(dist_hit), .off(dist_off), .span(dist_span)
  );

  mmio_rtr_slice #(.AW(AW), .NPORT(RTR_NPORT)) u_slice (
    .off(dist_off), .span(dist_span), .port(dist_port)
  );

  route_t sel;

  mmio_rtr_pick #(.NDIR(NDIR)) u_pick (
    .dir_hit(dir_hit), .dir_port(dir_port),
    .dist_hit(dist_hit), .dist_port(dist_port), .sel(sel)
  );

  route_t out_q;

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      out_q     <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      out_q     <= sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_hit      = out_q.hit;
  assign rsp_directed = out_q.directed;
  assign rsp_port     = out_q.port;
endmodule

// File: rtl/mmio_port_router_chk.sv
module mmio_port_router_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_hit,
  input logic          rsp_directed,
  input logic [PW-1:0] rsp_port
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_port)
      && $stable(rsp_hit) && $stable(rsp_directed));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !rsp_valid |=> !rsp_valid);

  a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_directed && rsp_port == '0);
endmodule

bind mmio_port_router mmio_port_router_chk #(.PW(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_directed(rsp_directed), .rsp_port(rsp_port)
);

// File: tb/sim_mmio_port_router.sv
`timescale 1ns/1ps
module sim_mmio_port_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_directed;
  logic [2:0]  rsp_port;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mmio_port_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_directed(rsp_directed),
    .rsp_port(rsp_port)
  );

  // {addr, hit, directed, port}
  localparam logic [36:0] VEC [15] = '{
    {32'hF4000000, 1'b1, 1'b0, 3'd0},
    {32'hF47FFFFF, 1'b1, 1'b0, 3'd0},
    {32'hF4900000, 1'b1, 1'b0, 3'd1},
    {32'hF4800000, 1'b1, 1'b1, 3'd2},
    {32'hF4800010, 1'b1, 1'b1, 3'd2},
    {32'hF7FFFFFF, 1'b1, 1'b0, 3'd7},
    {32'hF7000000, 1'b1, 1'b0, 3'd6},
    {32'hF8000000, 1'b0, 1'b0, 3'd0},
    {32'hF9000000, 1'b1, 1'b1, 3'd4},
    {32'hF9FFFFFF, 1'b1, 1'b1, 3'd4},
    {32'hFA000000, 1'b1, 1'b1, 3'd6},
    {32'hFBFFFFFF, 1'b1, 1'b1, 3'd6},
    {32'hFC000000, 1'b0, 1'b0, 3'd0},
    {32'hF3FFFFFF, 1'b0, 1'b0, 3'd0},
    {32'h00000000, 1'b0, 1'b0, 3'd0}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic route(string tag, logic [31:0] a, logic h, logic d, logic [2:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(h));
    check({tag, " dir"}, 32'(rsp_directed), 32'(d));
    check({tag, " port"}, 32'(rsp_port), 32'(p));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle req_ready", 32'(req_ready), 32'd1);
    for (int k = 0; k < 4; k++) begin
      rd_check("R1 reset dir base", 12'(12'h300 + 12'h18 * k), 32'h0);
      rd_check("R1 reset dir mask", 12'(12'h308 + 12'h18 * k), 32'h0);
      rd_check("R1 reset dir route", 12'(12'h310 + 12'h18 * k), 32'h0);
    end
    rd_check("R1 reset dist base", 12'h360, 32'h0);
    route("R8 all disabled", 32'hF4000000, 1'b0, 1'b0, 3'd0);

    // program windows
    wr(12'h360, 32'hF4000001); wr(12'h368, 32'hFC000000); wr(12'h370, 32'h0);
    wr(12'h300, 32'hF9000001); wr(12'h308, 32'hFF000000); wr(12'h310, 32'h0000000C);
    wr(12'h318, 32'hFA000001); wr(12'h320, 32'hFE000000); wr(12'h328, 32'h6);
    wr(12'h330, 32'hF4800001); wr(12'h338, 32'hFFF00000); wr(12'h340, 32'h2);
    wr(12'h348, 32'hF4800001); wr(12'h350, 32'hFFFF0000); wr(12'h358, 32'h5);
    wr(12'h378, 32'hDEADBEEF);

    rd_check("R1 readback dist base", 12'h360, 32'hF4000001);
    rd_check("R1 readback dir0 route", 12'h310, 32'h0000000C);
    rd_check("R1 readback dir3 mask", 12'h350, 32'hFFFF0000);
    rd_check("R1 unmapped reads zero", 12'h378, 32'h0);
    rd_check("R1 gap offset reads zero", 12'h304, 32'h0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9 (route bits [2:0] of 0xC give 4)
    for (int i = 0; i < 15; i++) begin
      route("R3/R4/R5/R6/R7 vec", VEC[i][36:5], VEC[i][4], VEC[i][3], VEC[i][2:0]);
    end

    // R7: disable dir2 -> dir3 takes over
    wr(12'h330, 32'hF4800000);
    route("R7 next window", 32'hF4800000, 1'b1, 1'b1, 3'd5);
    route("R2 disabled dir falls to slice", 32'hF4900000, 1'b1, 1'b0, 3'd1);

    // R8: distributed disabled
    wr(12'h360, 32'hF4000000);
    route("R8 dist disabled", 32'hF4000000, 1'b0, 1'b0, 3'd0);
    route("R8 directed still live", 32'hF9000000, 1'b1, 1'b1, 3'd4);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'hF9000000;
    @(negedge clk);
    check("R9 valid after accept", 32'(rsp_valid), 32'd1);
    check("R10 ready low in stall", 32'(req_ready), 32'd0);
    check("R10 first port", 32'(rsp_port), 32'd4);
    req_addr = 32'hFA000000;
    @(negedge clk);
    check("R10 held port", 32'(rsp_port), 32'd4);
    check("R10 held valid", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second port", 32'(rsp_port), 32'd6);
    check("R9 second valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    check("R9 drained", 32'(rsp_valid), 32'd0);

    finish_run();
  end
endmodule